// File: doc/BRIEF.md
# Operand Instruction Decoder and ALU

This block takes the first 16-bit word of an instruction together with the two operand values that another stage has already fetched. It recognises a small instruction subset and computes the value to be written back. The subset is clear, complement and increment, each in a word form and a byte form, plus a word add that has two operands. The block reports which operation was found and whether it is a byte operation. It also reports the source and destination specifier fields, the result, four condition flags, and either a write-back enable or an illegal-opcode flag.

The instruction word is read as octal digits. Bit 15 selects byte operation for the single-operand group. The add form holds two 6-bit specifiers at fixed positions. Each specifier packs a 3-bit mode and a 3-bit register, and this block passes them on without interpreting them. Every output is registered, so the results appear one clock after a valid instruction is presented. Address generation and operand fetch belong to the stages around this block.

Top module: `operand_unit`

## Requirements
- R1: Words 0050DD (octal) and 1050DD decode as clear, op_o = 1. The result is zero over the operated width and flags_o = 4'b0100.
- R2: Words 0052DD and 1052DD decode as increment, op_o = 3. The result is the destination plus one, wrapping within the operated width.
- R3: Words 0051DD and 1051DD decode as complement, op_o = 2. The result is the bitwise inverse of the destination over the operated width.
- R4: Words 06SSDD decode as add, op_o = 4, with byte_o = 0. The result is the 16-bit sum of src_val_i and dst_val_i.
- R5: When bit 15 is set in the single-operand group, byte_o = 1. Only bits 7:0 are operated on, and result bits 15:8 equal dst_val_i[15:8].
- R6: dst_spec_o is instruction bits 5:0. For add, src_spec_o is instruction bits 11:6. For the single-operand forms, src_spec_o is 0.
- R7: Any other word gives illegal_o = 1, op_o = 0, wr_en_o = 0, result_o = 0 and flags_o = 0. This includes 1SSDD with a leading 16, 0053DD and 1053DD.
- R8: flags_o is {N,Z,V,C}, with bit 3 as N, taken over the operated width. N is the result sign bit and Z means the result is zero. V is 0 for clear and complement. For increment, V is set when the result is the most negative value. For add, V is signed overflow. C is 0 for clear and increment, 1 for complement, and the carry out for add.
- R9: Outputs register one clock after valid_i. valid_o follows valid_i one clock later. When valid_i is low, all other outputs are zero on the next clock.
- R10: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction and operands are present |
| instr_i | input | 16 | First instruction word |
| src_val_i | input | 16 | Source operand value |
| dst_val_i | input | 16 | Destination operand value |
| valid_o | output | 1 | Registered outputs are valid |
| op_o | output | 3 | 0 none, 1 clear, 2 complement, 3 increment, 4 add |
| byte_o | output | 1 | Byte operation |
| src_spec_o | output | 6 | Source mode and register field |
| dst_spec_o | output | 6 | Destination mode and register field |
| result_o | output | 16 | Write-back value |
| flags_o | output | 4 | {N,Z,V,C} |
| wr_en_o | output | 1 | Write result to destination |
| illegal_o | output | 1 | Word is outside the subset |

## Verification
The assertions assume that valid_i and the operand values are settled before each rising clock edge. The byte pass-through check compares against dst_val_i as sampled at the previous edge. For that reason the stimulus changes inputs only on falling edges and holds them for a full period. The assertions also assume that valid_i is known at every edge after reset. The bench never leaves it undriven and returns it low between scenarios. Operand values are chosen to sit at the edges of the sign and carry boundaries, which are the points where the flag rules are most likely to be wrong.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int INSTR_W = 16;
  localparam int SPEC_W  = 6;
  localparam int OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 3'd0,
    OP_CLR  = 3'd1,
    OP_COM  = 3'd2,
    OP_INC  = 3'd3,
    OP_ADD  = 3'd4
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/opdec_decode.sv
module opdec_decode
  import opdec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output op_e                op_o,
  output logic               byte_o,
  output logic [SPEC_W-1:0]  src_spec_o,
  output logic [SPEC_W-1:0]  dst_spec_o,
  output logic               illegal_o
);
  op_e op_d;

  always_comb begin
    op_d = OP_NONE;
    // single-operand group: digit pattern x05ODD, O selects the operation
    if (instr_i[14:12] == 3'o0 && instr_i[11:9] == 3'o5) begin
      case (instr_i[8:6])
        3'o0:    op_d = OP_CLR;
        3'o1:    op_d = OP_COM;
        3'o2:    op_d = OP_INC;
        default: op_d = OP_NONE;
      endcase
    end else if (!instr_i[15] && instr_i[14:12] == 3'o6) begin
      op_d = OP_ADD;
    end
  end

  assign op_o       = op_d;
  assign illegal_o  = (op_d == OP_NONE);
  assign byte_o     = instr_i[15] && (op_d != OP_NONE) && (op_d != OP_ADD);
  assign src_spec_o = (op_d == OP_ADD) ? instr_i[11:6] : '0;
  assign dst_spec_o = instr_i[5:0];
endmodule

// File: rtl/opdec_alu.sv
module opdec_alu
  import opdec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] result_o,
  output flags_t            flags_o,
  output logic              wr_o
);
  localparam int BW = DATA_W / 2;

  logic [DATA_W:0]   wsum;
  logic [DATA_W-1:0] wres;
  logic              wv, wc;
  logic [BW:0]       bsum;
  logic [BW-1:0]     bres;
  logic              bv, bc;

  always_comb begin
    wsum = {1'b0, src_i} + {1'b0, dst_i};
    wres = '0;
    wv   = 1'b0;
    wc   = 1'b0;
    case (op_i)
      OP_COM: begin wres = ~dst_i; wc = 1'b1; end
      OP_INC: begin
        wres = dst_i + 1'b1;
        wv   = (wres == {1'b1, {(DATA_W-1){1'b0}}});
      end
      OP_ADD: begin
        wres = wsum[DATA_W-1:0];
        wc   = wsum[DATA_W];
        wv   = (src_i[DATA_W-1] == dst_i[DATA_W-1]) && (wres[DATA_W-1] != dst_i[DATA_W-1]);
      end
      default: wres = '0;
    endcase
  end

  always_comb begin
    bsum = {1'b0, src_i[BW-1:0]} + {1'b0, dst_i[BW-1:0]};
    bres = '0;
    bv   = 1'b0;
    bc   = 1'b0;
    case (op_i)
      OP_COM: begin bres = ~dst_i[BW-1:0]; bc = 1'b1; end
      OP_INC: begin
        bres = dst_i[BW-1:0] + 1'b1;
        bv   = (bres == {1'b1, {(BW-1){1'b0}}});
      end
      OP_ADD: begin
        bres = bsum[BW-1:0];
        bc   = bsum[BW];
        bv   = (src_i[BW-1] == dst_i[BW-1]) && (bres[BW-1] != dst_i[BW-1]);
      end
      default: bres = '0;
    endcase
  end

  always_comb begin
    wr_o = (op_i != OP_NONE);
    if (!wr_o) begin
      result_o = '0;
      flags_o  = '0;
    end else if (byte_i) begin
      result_o = {dst_i[DATA_W-1:BW], bres};
      flags_o  = '{n: bres[BW-1], z: (bres == '0), v: bv, c: bc};
    end else begin
      result_o = wres;
      flags_o  = '{n: wres[DATA_W-1], z: (wres == '0), v: wv, c: wc};
    end
  end
endmodule

// File: rtl/operand_unit.sv
module operand_unit
  import opdec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [15:0]       instr_i,
  input  logic [DATA_W-1:0] src_val_i,
  input  logic [DATA_W-1:0] dst_val_i,
  output logic              valid_o,
  output logic [2:0]        op_o,
  output logic              byte_o,
  output logic [5:0]        src_spec_o,
  output logic [5:0]        dst_spec_o,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o,
  output logic              wr_en_o,
  output logic              illegal_o
);
  localparam int BW = DATA_W / 2;

  op_e               dec_op;
  logic              dec_byte, dec_ill;
  logic [SPEC_W-1:0] dec_src, dec_dst;
  logic [DATA_W-1:0] alu_res;
  flags_t            alu_flags;
  logic              alu_wr;

  opdec_decode u_dec (
    .instr_i    (instr_i),
    .op_o       (dec_op),
    .byte_o     (dec_byte),
    .src_spec_o (dec_src),
    .dst_spec_o (dec_dst),
    .illegal_o  (dec_ill)
  );

  opdec_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i     (dec_op),
    .byte_i   (dec_byte),
    .src_i    (src_val_i),
    .dst_i    (dst_val_i),
    .result_o (alu_res),
    .flags_o  (alu_flags),
    .wr_o     (alu_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; op_o <= '0; byte_o <= 1'b0;
      src_spec_o <= '0; dst_spec_o <= '0; result_o <= '0;
      flags_o <= '0; wr_en_o <= 1'b0; illegal_o <= 1'b0;
    end else if (valid_i) begin
      valid_o    <= 1'b1;
      op_o       <= dec_op;
      byte_o     <= dec_byte;
      src_spec_o <= dec_src;
      dst_spec_o <= dec_dst;
      result_o   <= alu_res;
      flags_o    <= alu_flags;
      wr_en_o    <= alu_wr;
      illegal_o  <= dec_ill;
    end else begin
      valid_o <= 1'b0; op_o <= '0; byte_o <= 1'b0;
      src_spec_o <= '0; dst_spec_o <= '0; result_o <= '0;
      flags_o <= '0; wr_en_o <= 1'b0; illegal_o <= 1'b0;
    end
  end

  a_r7_illegal_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && result_o == '0 && flags_o == '0));
  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !wr_en_o && !illegal_o));
  a_r9_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot({illegal_o, wr_en_o}));
  a_r5_upper_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec_byte) |=> (byte_o && result_o[DATA_W-1:BW] == $past(dst_val_i[DATA_W-1:BW])));
  a_r1_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_o == 3'd1) |-> (result_o[BW-1:0] == '0 && flags_o == 4'b0100));
  a_r4_add_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_o == 3'd4) |-> !byte_o);
endmodule

// File: tb/operand_unit_bench.sv
module operand_unit_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instr = '0, src = '0, dst = '0;
  logic        valid_o, byte_o, wr_en_o, illegal_o;
  logic [2:0]  op_o;
  logic [5:0]  src_spec_o, dst_spec_o;
  logic [15:0] result_o;
  logic [3:0]  flags_o;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_unit u_operand_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .src_val_i(src), .dst_val_i(dst), .valid_o(valid_o), .op_o(op_o),
    .byte_o(byte_o), .src_spec_o(src_spec_o), .dst_spec_o(dst_spec_o),
    .result_o(result_o), .flags_o(flags_o), .wr_en_o(wr_en_o), .illegal_o(illegal_o)
  );

  // {valid,op,byte,src_spec,dst_spec,result,flags,wr,ill} = 39 bits
  function automatic logic [38:0] model(input logic v, input logic [15:0] w,
                                        input logic [15:0] s, input logic [15:0] d);
    int op; bit bm; int r, n, z, ov, c, width, mask, sv, dv, ssum;
    logic [5:0] ss;
    if (!v) return '0;
    op = 0; bm = 0; ss = '0;
    if (w[14:12] == 0 && w[11:9] == 5 && w[8:6] <= 2) begin
      op = (w[8:6] == 0) ? 1 : (w[8:6] == 1) ? 2 : 3;
      bm = w[15];
    end else if (w[15:12] == 4'o6) begin
      op = 4; ss = w[11:6];
    end
    if (op == 0) return {1'b1, 3'd0, 1'b0, 6'd0, w[5:0], 16'd0, 4'd0, 1'b0, 1'b1};
    width = bm ? 8 : 16;
    mask  = (1 << width) - 1;
    dv = int'(d) & mask; sv = int'(s) & mask;
    ov = 0; c = 0;
    case (op)
      1: r = 0;
      2: begin r = (~dv) & mask; c = 1; end
      3: begin r = (dv + 1) & mask; ov = (dv == (mask >> 1)); end
      default: begin
        r = (sv + dv) & mask; c = (sv + dv) > mask;
        ssum = $signed(s) + $signed(d);
        ov = (ssum > 32767 || ssum < -32768);
      end
    endcase
    n = (r >> (width - 1)) & 1;
    z = (r == 0);
    if (bm) r = r | (int'(d) & 32'hFF00);
    return {1'b1, 3'(op), bm, ss, w[5:0], 16'(r), 1'(n), 1'(z), 1'(ov), 1'(c), 1'b1, 1'b0};
  endfunction

  task automatic apply_check(input string tag, input logic v, input logic [15:0] w,
                             input logic [15:0] s, input logic [15:0] d);
    logic [38:0] exp, act;
    @(negedge clk);
    valid = v; instr = w; src = s; dst = d;
    @(negedge clk);
    exp = model(v, w, s, d);
    act = {valid_o, op_o, byte_o, src_spec_o, dst_spec_o, result_o, flags_o, wr_en_o, illegal_o};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s instr=%o act=%h exp=%h", tag, w, act, exp);
    end
    valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [38:0] act;
    act = {valid_o, op_o, byte_o, src_spec_o, dst_spec_o, result_o, flags_o, wr_en_o, illegal_o};
    n_vec++;
    if (act !== '0) begin n_bad++; $display("FAIL R10 act=%h exp=0", act); end
  endtask

  task automatic t_clear;
    apply_check("R1 clr", 1, 16'o005015, 16'h5555, 16'h1234);
    apply_check("R1 R5 clrb", 1, 16'o105015, 16'h0, 16'hAB34);
  endtask

  task automatic t_inc;
    apply_check("R2 R8 inc ovf", 1, 16'o005203, 16'h0, 16'h7FFF);
    apply_check("R2 R8 inc wrap", 1, 16'o005203, 16'h0, 16'hFFFF);
    apply_check("R2 R5 incb wrap", 1, 16'o105240, 16'h0, 16'h12FF);
    apply_check("R2 R8 incb ovf", 1, 16'o105240, 16'h0, 16'h007F);
  endtask

  task automatic t_com;
    apply_check("R3 com", 1, 16'o005150, 16'h0, 16'h00FF);
    apply_check("R3 R5 comb", 1, 16'o105150, 16'h0, 16'hF0F0);
  endtask

  task automatic t_add;
    apply_check("R4 R8 add ovf", 1, 16'o060204, 16'h7000, 16'h1000);
    apply_check("R4 R8 add carry", 1, 16'o060204, 16'hFFFF, 16'h0001);
    apply_check("R4 R6 add spec", 1, 16'o067201, 16'h1234, 16'h1111);
    apply_check("R4 R8 add neg", 1, 16'o062700, 16'h8000, 16'h8000);
  endtask

  task automatic t_illegal;
    apply_check("R7 op3", 1, 16'o005300, 16'h1, 16'h2);
    apply_check("R7 byte add", 1, 16'o160204, 16'h1, 16'h2);
    apply_check("R7 zero", 1, 16'o000000, 16'h1, 16'h2);
    apply_check("R7 ones", 1, 16'o177777, 16'h1, 16'h2);
    apply_check("R7 byte op3", 1, 16'o105304, 16'h1, 16'h2);
    apply_check("R7 other", 1, 16'o070000, 16'h1, 16'h2);
  endtask

  task automatic t_idle;
    apply_check("R9 idle", 0, 16'o060204, 16'h1, 16'h2);
    apply_check("R6 R9 after idle", 1, 16'o005277, 16'h0, 16'h0041);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_clear();
    t_inc();
    t_com();
    t_add();
    t_illegal();
    t_idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule